// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers completion events from up to sixteen DMA channels and folds them into a single level-sensitive interrupt line for the host. Every channel raises three kinds of event strobe: half-done, package-done and queue-done. Each event sets its own pending bit, whether or not that event is enabled. The interrupt line is high while any pending bit has its matching enable bit set.

The host reaches the block over a simple 32-bit register bus with a select, a write flag, a byte address and write data. Read data is combinational. Two enable registers and two pending registers hold four bits per channel. Channels 0 to 7 sit in the first register of each pair and channels 8 to 15 sit in the second. To acknowledge events, the host writes ones to pending bits. Writing back the value it just read clears exactly the events it has seen. The channel datapaths that produce the events are outside this block and appear only as input strobes.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, every enable and pending bit is zero and irqOut is low.
- R2: A strobe on evHalf[c], evPkg[c] or evQueue[c] sets pending bit 4*c+0, 4*c+1 or 4*c+2 respectively. For c < 8 this bit is in the pending register at address 0x10; for c >= 8 it is bit 4*(c-8)+k of the pending register at address 0x14. The bit is set regardless of the enable bits, and it stays set until cleared.
- R3: The enable registers at addresses 0x00 (channels 0-7) and 0x04 (channels 8-15) use the same bit layout as the pending registers. They read back the value last written to them.
- R4: Writing a one to a pending bit clears it. Writing a zero leaves it unchanged.
- R5: When an event strobe and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R6: irqOut is high exactly when some bit is set in both a pending register and the matching enable register. With all enables zero, irqOut stays low no matter which events are pending.
- R7: Bit 3 of every 4-bit field, and every field of a channel at or above NUM_CH, reads as zero and ignores writes, in both the enable and the pending registers.
- R8: Reads from any other address return zero, and writes to any other address change nothing.
- R9: Writing 0xFFFFFFFF to both pending registers clears every pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational, zero when not reading) |
| evHalf | input | NUM_CH | Per-channel half-done event strobe |
| evPkg | input | NUM_CH | Per-channel package-done event strobe |
| evQueue | input | NUM_CH | Per-channel queue-done event strobe |
| irqOut | output | 1 | Level interrupt to the host |

## Verification
Random traffic uses sparse event strobes on all three event kinds across all channels. This traffic is interleaved with random writes to the four live registers and to unused addresses, and the run tells the set path apart from the clear path and the enable gating. Directed cases place an event with no enable, confirm that the line stays low, and then enable that event alone, which separates the latch behaviour from the interrupt gating. Other directed cases cover a zero write, an event that coincides with a clear of the same bit, writes of ones into bit 3 of each field, and a full clear of both pending registers. These show whether each corner is handled by the clear mask, by the event priority or by the valid-bit mask.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_W   = 32;
  localparam int FIELD_W = 4;
  localparam int MAX_CH  = 16;

  // Decoded access strobes passed from bus control to the datapath
  typedef struct packed {
    logic enWr0;
    logic enWr1;
    logic pendWr0;
    logic pendWr1;
    logic rdEn0;
    logic rdEn1;
    logic rdPend0;
    logic rdPend1;
  } busStrobes_t;
endpackage

// File: rtl/irq_bus_ctrl.sv
module irq_bus_ctrl
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int EN0_OFF  = 'h00,
  parameter int EN1_OFF  = 'h04,
  parameter int PND0_OFF = 'h10,
  parameter int PND1_OFF = 'h14
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobes_t       strb
);
  logic hitEn0, hitEn1, hitPnd0, hitPnd1;

  always_comb begin
    hitEn0  = (busAddr == ADDR_W'(EN0_OFF));
    hitEn1  = (busAddr == ADDR_W'(EN1_OFF));
    hitPnd0 = (busAddr == ADDR_W'(PND0_OFF));
    hitPnd1 = (busAddr == ADDR_W'(PND1_OFF));

    strb.enWr0   = busSel &  busWr & hitEn0;
    strb.enWr1   = busSel &  busWr & hitEn1;
    strb.pendWr0 = busSel &  busWr & hitPnd0;
    strb.pendWr1 = busSel &  busWr & hitPnd1;
    strb.rdEn0   = busSel & ~busWr & hitEn0;
    strb.rdEn1   = busSel & ~busWr & hitEn1;
    strb.rdPend0 = busSel & ~busWr & hitPnd0;
    strb.rdPend1 = busSel & ~busWr & hitPnd1;
  end
endmodule

// File: rtl/irq_event_dp.sv
module irq_event_dp
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       strb,
  input  logic [REG_W-1:0]  wdata,
  input  logic [NUM_CH-1:0] evHalf,
  input  logic [NUM_CH-1:0] evPkg,
  input  logic [NUM_CH-1:0] evQueue,
  output logic [REG_W-1:0]  rdata,
  output logic              irqOut
);
  localparam int TOT_W = 2 * REG_W;
  localparam int SLOTS = TOT_W / FIELD_W;

  function automatic logic [TOT_W-1:0] buildMask();
    logic [TOT_W-1:0] m;
    m = '0;
    for (int s = 0; s < SLOTS; s++)
      if (s < NUM_CH)
        for (int b = 0; b < 3; b++) m[s*FIELD_W+b] = 1'b1;
    return m;
  endfunction

  localparam logic [TOT_W-1:0] VALID = buildMask();

  logic [TOT_W-1:0] enReg, pendReg;
  logic [TOT_W-1:0] enNext, pendNext;
  logic [TOT_W-1:0] evVec, clrVec, enWrVec, wdAll;

  // Event strobes mapped into the 4-bit field layout
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s < NUM_CH) begin : g_live
      assign evVec[s*FIELD_W+0] = evHalf[s];
      assign evVec[s*FIELD_W+1] = evPkg[s];
      assign evVec[s*FIELD_W+2] = evQueue[s];
      assign evVec[s*FIELD_W+3] = 1'b0;
    end else begin : g_dead
      assign evVec[s*FIELD_W +: FIELD_W] = '0;
    end
  end

  always_comb begin
    wdAll    = {wdata, wdata};
    enWrVec  = {{REG_W{strb.enWr1}}, {REG_W{strb.enWr0}}};
    clrVec   = wdAll & {{REG_W{strb.pendWr1}}, {REG_W{strb.pendWr0}}};
    enNext   = (enReg & ~enWrVec) | (wdAll & enWrVec & VALID);
    // event takes priority over a coincident clear
    pendNext = ((pendReg & ~clrVec) | evVec) & VALID;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= '0;
      pendReg <= '0;
    end else begin
      enReg   <= enNext;
      pendReg <= pendNext;
    end
  end

  always_comb begin
    unique case (1'b1)
      strb.rdEn0:   rdata = enReg[REG_W-1:0];
      strb.rdEn1:   rdata = enReg[TOT_W-1:REG_W];
      strb.rdPend0: rdata = pendReg[REG_W-1:0];
      strb.rdPend1: rdata = pendReg[TOT_W-1:REG_W];
      default:      rdata = '0;
    endcase
  end

  assign irqOut = |(pendReg & enReg);

  // R4: a written one clears a bit that saw no event that cycle
  a_r4_clear_one: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendReg & $past(clrVec & ~evVec)) == '0));

  // R5: a raised event is always visible the next cycle
  a_r5_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendReg & $past(evVec)) == $past(evVec)));

  // R2: a set pending bit stays set unless a one was written to it
  a_r2_hold_pending: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(pendReg) & ~$past(clrVec)) & ~pendReg) == '0));

  // R6: nothing enabled means no interrupt
  a_r6_no_enable_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (enReg == '0) |-> !irqOut);
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  logic [NUM_CH-1:0] evHalf,
  input  logic [NUM_CH-1:0] evPkg,
  input  logic [NUM_CH-1:0] evQueue,
  output logic              irqOut
);
  busStrobes_t strb;

  irq_bus_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strb   (strb)
  );

  irq_event_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wdata  (busWdata),
    .evHalf (evHalf),
    .evPkg  (evPkg),
    .evQueue(evQueue),
    .rdata  (busRdata),
    .irqOut (irqOut)
  );
endmodule

// File: tb/tb_dma_irq_agg.sv
`timescale 1ns/1ps
module tb_dma_irq_agg;
  localparam int NCH = 16;
  localparam logic [63:0] VAL = 64'h7777_7777_7777_7777;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NCH-1:0] evHalf = '0, evPkg = '0, evQueue = '0;
  logic        irqOut;

  int nChecks = 0, nFails = 0;
  logic [63:0] expEn = '0, expPend = '0;

  always #2.5 clk = ~clk;

  dma_irq_agg dut (.*);

  function automatic logic [63:0] evMap(logic [NCH-1:0] h, logic [NCH-1:0] p, logic [NCH-1:0] q);
    logic [63:0] v = '0;
    for (int c = 0; c < NCH; c++) begin
      v[c*4+0] = h[c]; v[c*4+1] = p[c]; v[c*4+2] = q[c];
    end
    return v;
  endfunction

  function automatic logic [31:0] expRead(logic [7:0] a);
    case (a)
      8'h00: return expEn[31:0];
      8'h04: return expEn[63:32];
      8'h10: return expPend[31:0];
      8'h14: return expPend[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the posedge, leave sampling point after it
  task automatic step(logic sel, logic wr, logic [7:0] a, logic [31:0] wd,
                      logic [NCH-1:0] h, logic [NCH-1:0] p, logic [NCH-1:0] q);
    logic [63:0] clr, wdAll;
    @(negedge clk);
    busSel = sel; busWr = wr; busAddr = a; busWdata = wd;
    evHalf = h; evPkg = p; evQueue = q;
    @(posedge clk);
    wdAll = {wd, wd};
    clr = '0;
    if (sel && wr && a == 8'h10) clr[31:0]  = wd;
    if (sel && wr && a == 8'h14) clr[63:32] = wd;
    if (sel && wr && a == 8'h00) expEn[31:0]  = wd & VAL[31:0];
    if (sel && wr && a == 8'h04) expEn[63:32] = wd & VAL[63:32];
    expPend = ((expPend & ~clr) | evMap(h, p, q)) & VAL;
    #1;
  endtask

  task automatic readChk(logic [7:0] a, string tag);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a; busWdata = '0;
    evHalf = '0; evPkg = '0; evQueue = '0;
    #1;
    check(tag, busRdata, expRead(a));
  endtask

  task automatic irqChk(string tag);
    check(tag, {31'b0, irqOut}, {31'b0, |(expEn & expPend)});
  endtask

  initial begin
    logic [7:0] addrs [6];
    addrs = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h08, 8'h20};
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R1: reset state
    irqChk("R1 irq after reset");
    readChk(8'h00, "R1 en0 reset"); readChk(8'h04, "R1 en1 reset");
    readChk(8'h10, "R1 pend0 reset"); readChk(8'h14, "R1 pend1 reset");

    // R2/R6: events with no enable latch but stay quiet
    step(0, 0, 0, 0, 16'h0001, 16'h0100, 16'h8000);
    irqChk("R6 no enable no irq");
    readChk(8'h10, "R2 pend0 ch0 half");
    readChk(8'h14, "R2 pend1 ch8 pkg ch15 queue");
    // R3/R6: enable ch15 queue alone
    step(1, 1, 8'h04, 32'h4000_0000, 0, 0, 0);
    readChk(8'h04, "R3 en1 readback");
    irqChk("R6 enabled pending raises irq");
    // R4: write zero no effect, then write one clears
    step(1, 1, 8'h14, 32'h0000_0000, 0, 0, 0);
    readChk(8'h14, "R4 zero write keeps");
    step(1, 1, 8'h14, 32'h4000_0000, 0, 0, 0);
    readChk(8'h14, "R4 one write clears");
    irqChk("R6 irq drops after clear");
    // R5: event and clear same cycle on ch0 half
    step(1, 1, 8'h10, 32'h0000_0001, 16'h0001, 0, 0);
    readChk(8'h10, "R5 event beats clear");
    // R7: bit 3 of fields ignores writes
    step(1, 1, 8'h00, 32'hFFFF_FFFF, 0, 0, 0);
    readChk(8'h00, "R7 en0 bit3 masked");
    check("R7 en0 literal", busRdata, 32'h7777_7777);
    // R8: unused address
    step(1, 1, 8'h08, 32'hFFFF_FFFF, 0, 0, 0);
    readChk(8'h08, "R8 unused reads zero");
    readChk(8'h04, "R8 en1 untouched");
    // R9: full clear
    step(0, 0, 0, 0, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    step(1, 1, 8'h10, 32'hFFFF_FFFF, 0, 0, 0);
    step(1, 1, 8'h14, 32'hFFFF_FFFF, 0, 0, 0);
    readChk(8'h10, "R9 pend0 cleared");
    readChk(8'h14, "R9 pend1 cleared");
    check("R9 pend1 literal", busRdata, 32'h0);

    // random traffic: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 1500; i++) begin
      logic [NCH-1:0] h, p, q;
      logic [7:0] a;
      logic doWr;
      h = NCH'($urandom & $urandom & $urandom);
      p = NCH'($urandom & $urandom & $urandom);
      q = NCH'($urandom & $urandom & $urandom);
      a = addrs[$urandom % 6];
      doWr = ($urandom % 3) != 0;
      step(doWr, 1'b1, a, $urandom, h, p, q);
      irqChk("R6 random irq");
      readChk(addrs[$urandom % 6], "R2 random readback");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule